// File: doc/BRIEF.md
# Predicated Lane-Merge Write Unit

This unit sits in front of a vector register write port and a store path. It takes a freshly computed result vector, the current contents of the destination, a 64-bit predicate and a lane-format code. Every lane whose predicate says "live" takes the new result. Every other lane keeps the old destination value. Killed lanes are merged, not cleared.

The same per-lane decision also drives 64 per-byte write enables, one for each byte of the 512-bit vector. A masked store can use these enables directly, so the data bytes of killed lanes do not matter there. A polarity input selects which predicate value means "live". The result is registered: merged data, byte enables and a valid flag appear together one clock after the inputs.

Top module: `lane_merge_unit`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock. `out_data` and `out_byte_en` belong to the inputs of that same earlier clock.
- R2: While `rst_n` is low at a clock edge, `out_valid`, `out_data` and `out_byte_en` are cleared to zero.
- R3: With `inv_pol` = 0, a lane is live when its control bit is 1 and killed when it is 0.
- R4: With `inv_pol` = 1 the sense is reversed: a lane is live when its control bit is 0 and killed when it is 1.
- R5: A lane's control bit is predicate bit `lane_index * bytes_per_lane`, which is the bit of its lowest byte. All other predicate bits inside a wider lane have no effect on the outputs.
- R6: `fmt` encodes the lane width: 0 = 8-bit lanes (64 lanes), 1 = 16-bit lanes (32 lanes), 2 = 32-bit lanes (16 lanes). The code 3 behaves exactly like 2. Every byte of a lane shares that lane's decision.
- R7: Each byte of a live lane outputs the byte of `new_data`, and each byte of a killed lane outputs the byte of `old_data`. A killed lane is never zero-filled.
- R8: `out_byte_en[b]` is 1 exactly when byte b (bits 8b+7..8b) lies in a live lane.
- R9: If `in_valid` is 0 at a clock edge, `out_valid` drops to 0 and `out_data` and `out_byte_en` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs on this cycle are to be merged |
| fmt | input | 2 | Lane width code (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| inv_pol | input | 1 | 0: predicate 1 means live; 1: predicate 0 means live |
| pred | input | 64 | Predicate, one bit per byte position |
| new_data | input | 512 | Freshly computed result vector |
| old_data | input | 512 | Current destination contents |
| out_valid | output | 1 | Registered valid |
| out_data | output | 512 | Merged vector |
| out_byte_en | output | 64 | Per-byte write enables for a masked store |

## Verification
The hardest case to reach is a wide lane whose upper predicate bits disagree with its control bit. Only the lowest bit of the lane may decide the outcome. Random predicates seldom make every upper bit contradict the control bit, so directed vectors set only the non-control bits (or only the control bits) for 16-bit and 32-bit lanes. Under both polarities, these vectors must give an all-killed or all-live result. Random traffic with `in_valid` toggling covers the hold behaviour and the unused format code.

// File: rtl/lane_merge_pkg.sv
// Shared types for the lane-merge unit.
// Assumes: the lane width code is 2 bits; code 3 is an alias of 32-bit lanes.
package lane_merge_pkg;
    typedef enum logic [1:0] {
        LF_B8   = 2'd0,
        LF_B16  = 2'd1,
        LF_B32  = 2'd2,
        LF_B32X = 2'd3
    } lane_fmt_e;
endpackage

// File: rtl/lane_live_decode.sv
// Per-byte live decision.
// Each byte looks up the control bit of the lane it belongs to: the predicate bit
// at the lane's lowest byte. That bit is then flipped when inverted polarity is
// selected. Purely combinational.
// Assumes: the predicate carries one bit per byte position.
module lane_live_decode
    import lane_merge_pkg::*;
#(
    parameter int NBYTES = 64
) (
    input  lane_fmt_e          fmt,
    input  logic               inv_pol,
    input  logic [NBYTES-1:0]  pred,
    output logic [NBYTES-1:0]  live
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam int IDX16 = b - (b % 2);
        localparam int IDX32 = b - (b % 4);
        logic ctl;
        // Pick the control bit of the lane that owns this byte.
        always_comb begin
            case (fmt)
                LF_B8:   ctl = pred[b];
                LF_B16:  ctl = pred[IDX16];
                default: ctl = pred[IDX32];
            endcase
        end
        // Apply the polarity selection.
        assign live[b] = ctl ^ inv_pol;
    end
endmodule

// File: rtl/lane_byte_merge.sv
// Byte-granular merge.
// A byte flagged live passes the new result; any other byte passes the old
// destination. Combinational.
// Assumes: data width is NBYTES * BYTE_W.
module lane_byte_merge #(
    parameter int NBYTES = 64,
    parameter int BYTE_W = 8,
    localparam int DW = NBYTES * BYTE_W
) (
    input  logic [DW-1:0]     new_data,
    input  logic [DW-1:0]     old_data,
    input  logic [NBYTES-1:0] live,
    output logic [DW-1:0]     merged
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_mux
        // Choose new or old for one byte.
        assign merged[b*BYTE_W +: BYTE_W] = live[b] ? new_data[b*BYTE_W +: BYTE_W]
                                                    : old_data[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/lane_merge_unit.sv
// Predicated lane-merge write unit (top).
// Decodes the per-byte live mask from the predicate, lane format and polarity,
// then merges new and old data. The merged vector, the byte enables and valid
// are registered together. Outputs hold while no valid input arrives.
// Assumes: synchronous active-low reset; predicate has one bit per data byte.
module lane_merge_unit
    import lane_merge_pkg::*;
#(
    parameter int DATA_W = 512,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          fmt,
    input  logic                inv_pol,
    input  logic [NBYTES-1:0]   pred,
    input  logic [DATA_W-1:0]   new_data,
    input  logic [DATA_W-1:0]   old_data,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data,
    output logic [NBYTES-1:0]   out_byte_en
);
    localparam logic [NBYTES-1:0] PAIR_MASK = {(NBYTES/2){2'b01}};
    localparam logic [NBYTES-1:0] QUAD_MASK = {(NBYTES/4){4'b0111}};

    lane_fmt_e           fmt_e;
    logic [NBYTES-1:0]   live;
    logic [DATA_W-1:0]   merged;

    assign fmt_e = lane_fmt_e'(fmt);

    lane_live_decode #(.NBYTES(NBYTES)) u_decode (
        .fmt     (fmt_e),
        .inv_pol (inv_pol),
        .pred    (pred),
        .live    (live)
    );

    lane_byte_merge #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_merge (
        .new_data (new_data),
        .old_data (old_data),
        .live     (live),
        .merged   (merged)
    );

    // Register valid every cycle; register data and enables only on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_byte_en <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data    <= merged;
                out_byte_en <= live;
            end
        end
    end

    // Byte enables widened to bit level, used only by the checks below.
    logic [DATA_W-1:0] en_bits;
    for (genvar b = 0; b < NBYTES; b++) begin : g_en
        assign en_bits[b*BYTE_W +: BYTE_W] = {BYTE_W{out_byte_en[b]}};
    end

    // R1: the output valid is the input valid one clock later.
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R7: enabled bytes carry the new data that was presented.
    a_r7_live_new: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_data ^ $past(new_data)) & en_bits) == '0));

    // R7: disabled bytes carry the old destination, never zero.
    a_r7_killed_old: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_data ^ $past(old_data)) & ~en_bits) == '0));

    // R6: 16-bit lanes enable both bytes or neither.
    a_r6_pair_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_e == LF_B16) |=>
            (((out_byte_en ^ (out_byte_en >> 1)) & PAIR_MASK) == '0));

    // R6: 32-bit lanes (codes 2 and 3) enable all four bytes or none.
    a_r6_quad_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt[1]) |=>
            (((out_byte_en ^ (out_byte_en >> 1)) & QUAD_MASK) == '0));

    // R9: with no valid input the outputs hold and valid drops.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_byte_en)));
endmodule

// File: tb/lane_merge_unit_test.sv
`timescale 1ns/1ps
module lane_merge_unit_test;
    localparam int DW = 512;
    localparam int NB = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    fmt;
    logic          inv_pol;
    logic [NB-1:0] pred;
    logic [DW-1:0] new_data, old_data;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic [NB-1:0] out_byte_en;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string phase = "R2 reset";

    // Reference model state.
    logic          m_valid;
    logic [DW-1:0] m_data;
    logic [NB-1:0] m_be;

    lane_merge_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
        .inv_pol(inv_pol), .pred(pred), .new_data(new_data),
        .old_data(old_data), .out_valid(out_valid), .out_data(out_data),
        .out_byte_en(out_byte_en)
    );

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] rand_vec();
        logic [DW-1:0] v;
        for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Behavioural model of which bytes are live.
    function automatic logic [NB-1:0] model_live(logic [1:0] f, logic p, logic [NB-1:0] pr);
        logic [NB-1:0] r;
        int width;
        width = (f == 2'd0) ? 1 : (f == 2'd1) ? 2 : 4;
        for (int b = 0; b < NB; b++) begin
            logic c;
            c = pr[(b / width) * width];
            r[b] = p ? ~c : c;
        end
        return r;
    endfunction

    task automatic compare();
        vectors++;
        if (out_valid !== m_valid) begin
            errors++;
            $display("FAIL %s (R1 valid): got %0b expected %0b", phase, out_valid, m_valid);
        end
        vectors++;
        if (out_byte_en !== m_be) begin
            errors++;
            $display("FAIL %s (R8 byte enables): got %h expected %h", phase, out_byte_en, m_be);
        end
        vectors++;
        if (out_data !== m_data) begin
            errors++;
            $display("FAIL %s (R7 data): got %h expected %h", phase, out_data, m_data);
        end
    endtask

    // Drive one cycle of inputs, advance the model, and compare at the next negedge.
    task automatic apply(input logic v, input logic [1:0] f, input logic p,
                         input logic [NB-1:0] pr, input logic [DW-1:0] nd,
                         input logic [DW-1:0] od);
        logic [NB-1:0] lv;
        in_valid = v; fmt = f; inv_pol = p; pred = pr; new_data = nd; old_data = od;
        lv = model_live(f, p, pr);
        m_valid = v;
        if (v) begin
            m_be = lv;
            for (int b = 0; b < NB; b++)
                m_data[b*8 +: 8] = lv[b] ? nd[b*8 +: 8] : od[b*8 +: 8];
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        logic [DW-1:0] ones, a5, zeros;
        ones = '1; zeros = '0;
        a5 = {(DW/8){8'hA5}};
        rst_n = 0; in_valid = 0; fmt = 0; inv_pol = 0; pred = '0;
        new_data = '1; old_data = '1;
        m_valid = 0; m_data = '0; m_be = '0;
        repeat (3) @(negedge clk);
        phase = "R2 reset";
        compare();
        rst_n = 1;

        // R3: 8-bit lanes, true polarity.
        phase = "R3 true polarity";
        apply(1, 2'd0, 0, 64'hF0F0_0F0F_1234_8001, a5, ~a5);
        // R4: same vector, inverted polarity.
        phase = "R4 inverted polarity";
        apply(1, 2'd0, 1, 64'hF0F0_0F0F_1234_8001, a5, ~a5);
        // R5: 16-bit lanes with only non-control bits set.
        phase = "R5 b16 non-control bits";
        apply(1, 2'd1, 0, 64'hAAAA_AAAA_AAAA_AAAA, ones, a5);
        apply(1, 2'd1, 1, 64'hAAAA_AAAA_AAAA_AAAA, ones, a5);
        apply(1, 2'd1, 0, 64'h5555_5555_5555_5555, a5, zeros);
        // R5: 32-bit lanes, upper bits only, then control bits only.
        phase = "R5 b32 non-control bits";
        apply(1, 2'd2, 0, 64'hEEEE_EEEE_EEEE_EEEE, ones, a5);
        apply(1, 2'd2, 0, 64'h1111_1111_1111_1111, a5, ones);
        // R6: format code 3 equals 32-bit lanes.
        phase = "R6 fmt code 3";
        apply(1, 2'd3, 0, 64'h0000_0000_0000_0011, ones, zeros);
        apply(1, 2'd3, 1, 64'h8000_0010_0000_0001, a5, ones);
        // R7: killed lanes hold nonzero old data; live lanes take zero new data.
        phase = "R7 merge not zero-fill";
        apply(1, 2'd0, 0, 64'h0, a5, ones);
        apply(1, 2'd1, 0, 64'h0000_FFFF_0000_FFFF, zeros, ones);
        // R9: invalid cycles with changing inputs must not disturb outputs.
        phase = "R9 hold";
        apply(0, 2'd0, 1, 64'h1234_5678_9ABC_DEF0, zeros, zeros);
        apply(0, 2'd2, 0, '1, ones, a5);
        // R8 and the rest: random traffic.
        phase = "R8 random";
        for (int i = 0; i < 400; i++)
            apply(($urandom % 4) != 0, 2'($urandom), 1'($urandom),
                  {$urandom, $urandom}, rand_vec(), rand_vec());
        // R2: reset clears outputs again.
        phase = "R2 second reset";
        rst_n = 0; in_valid = 1;
        m_valid = 0; m_data = '0; m_be = '0;
        @(negedge clk);
        compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule